// File: doc/BRIEF.md
# Actuator Command and Status Bus Slave

This block is a bus slave for a synchronous external bus that uses an active-low start strobe, a read/write line, a two-bit transfer-size code and an active-low acknowledge. It holds the two registers of a linear motion controller. One is a read-only 8-bit status byte, and the other is a write-only 16-bit command word that carries a direction and a distance. Both registers sit in one word of the address map. The status byte is at byte offset 3 and the command half-word is at byte offset 2.

Any access to the block's high-address region is acknowledged with no wait states. Only a byte read at offset 3 enables the status byte onto the read lanes. Only a half-word write at offset 2 loads the command word. The decode is registered on the rising edge, and the acknowledge and enables are driven from the following falling edge. This gives the bus master and the register half a cycle of margin on each side. Each command load also raises a one-cycle move-start pulse for the motion logic. The block keeps a movement-done flag, which the motion logic sets through a done input and which every command write clears.

Top module: `act_reg_slave`

## Requirements
- R1: `ta_n` goes low for exactly one cycle after a rising edge at which `ts_n` was 0 and `addr_hi` equalled 6'h28, whatever `rw_n`, `tsize` or `addr_lo` were. `ta_n` stays high after an edge at which `ts_n` was 1 or `addr_hi` differed.
- R2: The decode is captured on a rising edge. `ta_n`, `rd_en` and `wr_en` change only on the following falling edge and hold for one full clock period, until the next falling edge.
- R3: `rd_en` asserts only for an acknowledged access with `rw_n`=1 (read), `addr_lo`=3 and `tsize`=2'b01 (byte).
- R4: `wr_en` asserts only for an acknowledged access with `rw_n`=0 (write), `addr_lo`=2 and `tsize`=2'b10 (half-word).
- R5: `dout_en` always equals `rd_en`.
- R6: The command register `cmd` takes `wdata` (data lanes 16-31, with `wdata[15]` on lane 16) at the rising edge that ends the `wr_en` cycle. `cmd[15]` is the direction (0 forward, 1 backward) and `cmd[14:0]` is the distance in 1 mm steps. No other access changes `cmd`.
- R7: The status done flag is set at a rising edge where `move_done`=1. It is cleared at the rising edge that loads `cmd`, and this clear wins over a concurrent `move_done`. Reads do not change the flag.
- R8: While `rd_en` is 1, `rdata` (lanes 24-31) carries the done flag in bit 0 and zeros in bits 7-1. While `rd_en` is 0, `rdata` is high impedance and `dout_en` is 0.
- R9: `move_start` is 1 for exactly the one cycle after each `cmd` load and 0 at all other times.
- R10: While `rst` is high at a rising and a falling edge, `ta_n` is 1, `rd_en`, `wr_en`, `dout_en` and `move_start` are 0, `cmd` is 0 and the done flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_n | input | 1 | Transfer start strobe, active low |
| rw_n | input | 1 | 1 = read, 0 = write |
| addr_hi | input | 6 | High address field (bits 6-11) |
| addr_lo | input | 8 | Low address field (bits 24-31) |
| tsize | input | 2 | Transfer size code: 01 byte, 10 half-word |
| wdata | input | 16 | Write data lanes 16-31 |
| move_done | input | 1 | Movement finished, from motion logic |
| ta_n | output | 1 | Transfer acknowledge, active low |
| rd_en | output | 1 | Status read enable |
| wr_en | output | 1 | Command write enable |
| dout_en | output | 1 | Data output driver enable |
| rdata | output | 8 | Read data lanes 24-31, tri-stated when idle |
| cmd | output | 16 | Command register (direction, distance) |
| move_start | output | 1 | One-cycle pulse after each command load |

## Verification
An access is presented before rising edge k and captured at that edge. The acknowledge and enables appear half a cycle later, after the falling edge, and they clear at the next falling edge. `cmd`, `move_start` and the cleared done flag update at rising edge k+1. The bench drives inputs on falling edges. It checks the enables just after the falling edge that follows capture, checks the command and pulse just after rising edge k+1, and checks for release just after the next falling edge. An exhaustive sweep over strobe, direction, size, low offset 0-7 and three high-address values compares every result with a decode computed in the bench.

// File: rtl/act_pkg.sv
package act_pkg;

    localparam int HI_W     = 6;
    localparam int LO_W     = 8;
    localparam int SZ_W     = 2;
    localparam int CMD_W    = 16;
    localparam int STAT_W   = 8;

    localparam logic [HI_W-1:0] BASE_HI    = 6'h28;
    localparam logic [LO_W-1:0] STAT_OFS   = 8'd3;
    localparam logic [LO_W-1:0] CMD_OFS    = 8'd2;
    localparam logic [SZ_W-1:0] SZ_BYTE    = 2'b01;
    localparam logic [SZ_W-1:0] SZ_HALF    = 2'b10;

    typedef struct packed {
        logic hit;
        logic rd;
        logic wr;
    } sel_t;

    function automatic sel_t decode_access(
        input logic            strobe_n,
        input logic            read_n,
        input logic [HI_W-1:0] hi,
        input logic [LO_W-1:0] lo,
        input logic [SZ_W-1:0] sz
    );
        sel_t s;
        s.hit = !strobe_n && (hi == BASE_HI);
        s.rd  = s.hit &&  read_n && (lo == STAT_OFS) && (sz == SZ_BYTE);
        s.wr  = s.hit && !read_n && (lo == CMD_OFS)  && (sz == SZ_HALF);
        return s;
    endfunction

endpackage

// File: rtl/act_phase.sv
module act_phase
    import act_pkg::*;
#(
    parameter int DW = CMD_W
)(
    input  logic          clk,
    input  logic          rst,
    input  sel_t          sel_in,
    input  logic [DW-1:0] data_in,
    output sel_t          sel_out,
    output logic [DW-1:0] data_hold
);
    sel_t sel_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_rise  <= '0;
            data_hold <= '0;
        end else begin
            sel_rise <= sel_in;
            if (sel_in.wr) data_hold <= data_in;
        end
    end

    always_ff @(negedge clk) begin
        if (rst) sel_out <= '0;
        else     sel_out <= sel_rise;
    end
endmodule

// File: rtl/act_cmd_reg.sv
module act_cmd_reg
    import act_pkg::*;
#(
    parameter int DW = CMD_W
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    output logic [DW-1:0] value,
    output logic          start
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
            start <= 1'b0;
        end else begin
            start <= load;
            if (load) value <= load_data;
        end
    end
endmodule

// File: rtl/act_status.sv
module act_status
    import act_pkg::*;
#(
    parameter int SW = STAT_W
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_load,
    input  logic          done_in,
    input  logic          rd_on,
    output logic          done_flag,
    output logic [SW-1:0] lanes
);
    localparam int PAD_W = SW - 1;

    always_ff @(posedge clk) begin
        if (rst)           done_flag <= 1'b0;
        else if (cmd_load) done_flag <= 1'b0;
        else if (done_in)  done_flag <= 1'b1;
    end

    assign lanes = rd_on ? {{PAD_W{1'b0}}, done_flag} : {SW{1'bz}};
endmodule

// File: rtl/act_reg_slave.sv
module act_reg_slave
    import act_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ts_n,
    input  logic              rw_n,
    input  logic [HI_W-1:0]   addr_hi,
    input  logic [LO_W-1:0]   addr_lo,
    input  logic [SZ_W-1:0]   tsize,
    input  logic [CMD_W-1:0]  wdata,
    input  logic              move_done,
    output logic              ta_n,
    output logic              rd_en,
    output logic              wr_en,
    output logic              dout_en,
    output logic [STAT_W-1:0] rdata,
    output logic [CMD_W-1:0]  cmd,
    output logic              move_start
);
    sel_t             sel_now;
    sel_t             sel_fall;
    logic [CMD_W-1:0] wdata_q;
    logic             done_q;

    assign sel_now = decode_access(ts_n, rw_n, addr_hi, addr_lo, tsize);

    act_phase #(.DW(CMD_W)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .sel_in    (sel_now),
        .data_in   (wdata),
        .sel_out   (sel_fall),
        .data_hold (wdata_q)
    );

    assign ta_n    = !sel_fall.hit;
    assign rd_en   = sel_fall.rd;
    assign wr_en   = sel_fall.wr;
    assign dout_en = sel_fall.rd;

    act_cmd_reg #(.DW(CMD_W)) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .load      (sel_fall.wr),
        .load_data (wdata_q),
        .value     (cmd),
        .start     (move_start)
    );

    act_status #(.SW(STAT_W)) u_stat (
        .clk       (clk),
        .rst       (rst),
        .cmd_load  (sel_fall.wr),
        .done_in   (move_done),
        .rd_on     (sel_fall.rd),
        .done_flag (done_q),
        .lanes     (rdata)
    );
endmodule

// File: rtl/act_reg_slave_chk.sv
module act_reg_slave_chk
    import act_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ts_n,
    input logic              rw_n,
    input logic [HI_W-1:0]   addr_hi,
    input logic              ta_n,
    input logic              rd_en,
    input logic              wr_en,
    input logic              dout_en,
    input logic [CMD_W-1:0]  cmd,
    input logic              move_start,
    input logic              done_q
);
    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= !rst;

    AST_ACK_ON_HIT: assert property (@(posedge clk) disable iff (rst || !armed)
        ta_n == !($past(!ts_n) && ($past(addr_hi) == BASE_HI))); // R1
    AST_RD_NEEDS_READ: assert property (@(posedge clk) disable iff (rst || !armed)
        rd_en |-> (!ta_n && $past(rw_n))); // R3
    AST_WR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst || !armed)
        wr_en |-> (!ta_n && !$past(rw_n))); // R4
    AST_OUT_EN_MATCH: assert property (@(posedge clk) disable iff (rst || !armed)
        dout_en == rd_en); // R5
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst || !armed)
        !$past(wr_en) |-> $stable(cmd)); // R6
    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(wr_en) |-> !done_q); // R7
    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst || !armed)
        move_start |-> $past(wr_en)); // R9
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst || !armed)
        move_start |=> !move_start); // R9
endmodule

bind act_reg_slave act_reg_slave_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ts_n       (ts_n),
    .rw_n       (rw_n),
    .addr_hi    (addr_hi),
    .ta_n       (ta_n),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .dout_en    (dout_en),
    .cmd        (cmd),
    .move_start (move_start),
    .done_q     (done_q)
);

// File: tb/act_reg_slave_test.sv
`timescale 1ns/1ps
module act_reg_slave_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ts_n = 1'b1;
    logic        rw_n = 1'b1;
    logic [5:0]  addr_hi = '0;
    logic [7:0]  addr_lo = '0;
    logic [1:0]  tsize = '0;
    logic [15:0] wdata = '0;
    logic        move_done = 1'b0;
    logic        ta_n, rd_en, wr_en, dout_en, move_start;
    logic [7:0]  rdata;
    logic [15:0] cmd;

    int checks = 0;
    int fails  = 0;
    logic [15:0] exp_cmd = '0;
    logic        exp_flag = 1'b0;
    bit          done_run = 0;

    always #5 clk = ~clk;

    act_reg_slave uut (
        .clk(clk), .rst(rst), .ts_n(ts_n), .rw_n(rw_n), .addr_hi(addr_hi),
        .addr_lo(addr_lo), .tsize(tsize), .wdata(wdata), .move_done(move_done),
        .ta_n(ta_n), .rd_en(rd_en), .wr_en(wr_en), .dout_en(dout_en),
        .rdata(rdata), .cmd(cmd), .move_start(move_start)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One access: inputs set after a falling edge, captured at rising edge k.
    task automatic access(input logic s_n, input logic r_n, input logic [5:0] hi,
                          input logic [7:0] lo, input logic [1:0] sz,
                          input logic [15:0] d, input logic hold_done);
        logic hit, rd, wr;
        hit = !s_n && (hi == 6'h28);
        rd  = hit && r_n && (lo == 8'd3) && (sz == 2'b01);
        wr  = hit && !r_n && (lo == 8'd2) && (sz == 2'b10);
        @(negedge clk); #1;
        check("R2 idle ack", {31'b0, ta_n}, 32'd1);
        check("R2 idle en", {30'b0, rd_en, wr_en}, 32'd0);
        ts_n = s_n; rw_n = r_n; addr_hi = hi; addr_lo = lo; tsize = sz; wdata = d;
        @(posedge clk); #1;
        check("R2 no early ack", {31'b0, ta_n}, 32'd1);
        ts_n = 1'b1; wdata = ~d;
        @(negedge clk); #1;
        check("R1 ack", {31'b0, ta_n}, {31'b0, !hit});
        check("R3 rd_en", {31'b0, rd_en}, {31'b0, rd});
        check("R4 wr_en", {31'b0, wr_en}, {31'b0, wr});
        check("R5 dout_en", {31'b0, dout_en}, {31'b0, rd});
        if (rd) check("R8 status byte", {24'b0, rdata}, {31'b0, exp_flag});
        @(posedge clk); #1;
        if (wr) begin
            exp_cmd  = d;
            exp_flag = 1'b0;
        end
        if (hold_done) move_done = 1'b0;
        check("R2 ack held", {31'b0, ta_n}, {31'b0, !hit});
        check("R6 cmd", {16'b0, cmd}, {16'b0, exp_cmd});
        check("R9 move_start", {31'b0, move_start}, {31'b0, wr});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R10 ta_n", {31'b0, ta_n}, 32'd1);
        check("R10 enables", {29'b0, rd_en, wr_en, dout_en}, 32'd0);
        check("R10 cmd", {16'b0, cmd}, 32'd0);
        check("R10 move_start", {31'b0, move_start}, 32'd0);
        @(negedge clk); rst = 1'b0;

        // R8: flag clear after reset, read returns zeros
        access(1'b0, 1'b1, 6'h28, 8'd3, 2'b01, 16'h0, 1'b0);

        // Exhaustive sweep (R1, R3, R4, R5, R6, R9)
        for (int s = 0; s < 2; s++)
            for (int r = 0; r < 2; r++)
                for (int h = 0; h < 3; h++)
                    for (int z = 0; z < 4; z++)
                        for (int l = 0; l < 8; l++) begin
                            logic [5:0] hv;
                            hv = (h == 0) ? 6'h28 : (h == 1) ? 6'h29 : 6'h08;
                            access(s[0], r[0], hv, l[7:0], z[1:0],
                                   16'(16'h1357 + (s*768 + r*384 + h*128 + z*32 + l) * 16'd97),
                                   1'b0);
                        end
        // a known backward command, direction bit set (R6)
        access(1'b0, 1'b0, 6'h28, 8'd2, 2'b10, 16'h8123, 1'b0);
        check("R6 direction", {31'b0, cmd[15]}, 32'd1);

        // R7: done input sets flag, read shows it, read keeps it
        @(negedge clk); move_done = 1'b1;
        @(negedge clk); move_done = 1'b0;
        exp_flag = 1'b1;
        access(1'b0, 1'b1, 6'h28, 8'd3, 2'b01, 16'h0, 1'b0);
        access(1'b0, 1'b1, 6'h28, 8'd3, 2'b01, 16'h0, 1'b0);
        // R7: write with move_done high at the load edge: clear wins
        @(negedge clk); move_done = 1'b1;
        access(1'b0, 1'b0, 6'h28, 8'd2, 2'b10, 16'h0042, 1'b1);
        access(1'b0, 1'b1, 6'h28, 8'd3, 2'b01, 16'h0, 1'b0);
        check("R7 flag cleared", {31'b0, exp_flag}, 32'd0);

        done_run = 1;
    end

    initial begin
        fork
            wait (done_run);
            begin
                repeat (20000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule